// File: doc/BRIEF.md
# Spiking Margin Propagation Unit

This block is a clocked network of three integrate-and-fire neurons that works on one-bit spike streams. Two input streams carry rates L1 and L2, and a third stream carries a constraint rate γ. The block produces a result stream z. In the long run, the rate of z settles to the value that satisfies [L1 - z]+ + [L2 - z]+ = γ. This gives a piecewise-linear stand-in for log-sum-exp, computed directly on spike rates.

Each neuron keeps a signed membrane value. Once per clock, the membrane moves one step up for every excitatory spike and one step down for every inhibitory spike that arrives in that sample. The membrane saturates at ±LIM. A neuron spikes, through a register, whenever its new membrane value lies above zero. The two input neurons are excited by their own input stream and inhibited by their own previous spike and by z. The result neuron is excited by the two input neurons and inhibited by γ. The sum of the input-neuron rates is therefore held at γ, and each input-neuron rate tracks the part of its input that exceeds z.

Top module: `spk_mp_unit`

## Requirements
- R1: While reset is asserted at a clock edge, all three membranes become 0 and all three spike outputs become 0.
- R2: At each clock edge, every membrane moves by STEP × (excitatory count − inhibitory count). Neuron one counts l1_spk as excitation and its own previous spike plus the previous z spike as inhibition. Neuron two does the same with l2_spk. The z neuron counts the previous t1 and t2 spikes as excitation and gam_spk as inhibition. The input spikes used are the ones present at that edge.
- R3: A spike output is 1 in the cycle after an edge exactly when the membrane written at that edge is above 0.
- R4: Membranes saturate at +LIM and −LIM and never wrap. A membrane held at −LIM with no excitation stays at −LIM.
- R5: When z stays silent (γ rate above L1 + L2), the long-run rate of t1 equals the rate of L1 and the rate of t2 equals the rate of L2, within 0.03.
- R6: In steady state, rate(t1) + rate(t2) equals rate(γ) within 0.03, whenever γ is below L1 + L2.
- R7: In steady state, rate(t1) equals max(rate(L1) − rate(z), 0), and rate(t2) equals max(rate(L2) − rate(z), 0), each within 0.03.
- R8: The rate of z matches the margin-propagation solution within 0.03. This is (L1 + L2 − γ)/2 when both inputs lie above that value. Otherwise it is max(L1, L2) − γ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l1_spk | input | 1 | First input spike stream |
| l2_spk | input | 1 | Second input spike stream |
| gam_spk | input | 1 | Constraint spike stream that inhibits the z neuron |
| t1_spk | output | 1 | Registered spike of neuron one |
| t2_spk | output | 1 | Registered spike of neuron two |
| z_spk | output | 1 | Registered result spike |
| t1_mem | output | MEM_W | Signed membrane of neuron one |
| t2_mem | output | MEM_W | Signed membrane of neuron two |
| z_mem | output | MEM_W | Signed membrane of the result neuron |

## Verification
The hardest condition to reach from the ports is a membrane sitting at its saturation bound. Normally the feedback loop keeps every membrane close to zero, so a bound is only touched when one rate clearly outweighs the others. The bench holds γ at a constant one with no input activity, which drives the z membrane straight down onto −LIM. It then switches on a steady input and confirms that the membrane climbs off the floor one step per cycle. The rate relations are checked separately with long pseudo-random streams at several L1 positions around the two knees of the margin-propagation curve.

// File: rtl/spk_mp_pkg.sv
package spk_mp_pkg;

  // Limit a wide membrane sum to the symmetric band [-lim, +lim].
  function automatic logic signed [31:0] clamp_mem(input logic signed [31:0] v,
                                                   input int lim);
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    hi = lim;
    lo = -lim;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Firing rule: the spike is set when the membrane lies above the threshold.
  function automatic logic above_thr(input logic signed [31:0] v, input int thr);
    logic signed [31:0] t;
    t = thr;
    return v > t;
  endfunction

endpackage

// File: rtl/spk_delta.sv
module spk_delta #(
  parameter int N_EXC = 1,
  parameter int N_INH = 1,
  parameter int STEP  = 1
) (
  input  logic [N_EXC-1:0]  exc,
  input  logic [N_INH-1:0]  inh,
  output logic signed [31:0] delta
);
  logic signed [31:0] up_sum;
  logic signed [31:0] dn_sum;

  always_comb begin
    up_sum = '0;
    for (int i = 0; i < N_EXC; i++) begin
      if (exc[i]) up_sum = up_sum + STEP;
    end
  end

  always_comb begin
    dn_sum = '0;
    for (int i = 0; i < N_INH; i++) begin
      if (inh[i]) dn_sum = dn_sum + STEP;
    end
  end

  assign delta = up_sum - dn_sum;
endmodule

// File: rtl/spk_neuron.sv
module spk_neuron #(
  parameter int N_EXC = 1,
  parameter int N_INH = 1,
  parameter int MEM_W = 8,
  parameter int LIM   = 100,
  parameter int STEP  = 1,
  parameter int THR   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_EXC-1:0]        exc,
  input  logic [N_INH-1:0]        inh,
  output logic signed [MEM_W-1:0] mem,
  output logic                    spk
);
  logic signed [31:0]      delta;
  logic signed [31:0]      mem_wide;
  logic signed [31:0]      mem_nxt;
  logic signed [MEM_W-1:0] mem_q;
  logic                    spk_q;
  logic                    fire_d;

  spk_delta #(.N_EXC(N_EXC), .N_INH(N_INH), .STEP(STEP)) u_delta (
    .exc   (exc),
    .inh   (inh),
    .delta (delta)
  );

  assign mem_wide = 32'(mem_q);
  assign mem_nxt  = spk_mp_pkg::clamp_mem(mem_wide + delta, LIM);
  assign fire_d   = spk_mp_pkg::above_thr(mem_nxt, THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
      spk_q <= 1'b0;
    end else begin
      mem_q <= mem_nxt[MEM_W-1:0];
      spk_q <= fire_d;
    end
  end

  assign mem = mem_q;
  assign spk = spk_q;
endmodule

// File: rtl/spk_mp_unit.sv
module spk_mp_unit #(
  parameter int MEM_W = 8,
  parameter int LIM   = 100,
  parameter int STEP  = 1,
  parameter int THR   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    l1_spk,
  input  logic                    l2_spk,
  input  logic                    gam_spk,
  output logic                    t1_spk,
  output logic                    t2_spk,
  output logic                    z_spk,
  output logic signed [MEM_W-1:0] t1_mem,
  output logic signed [MEM_W-1:0] t2_mem,
  output logic signed [MEM_W-1:0] z_mem
);
  // Registered spikes of the three neurons; they close the feedback loops.
  logic t1_q;
  logic t2_q;
  logic z_q;

  spk_neuron #(.N_EXC(1), .N_INH(2), .MEM_W(MEM_W), .LIM(LIM), .STEP(STEP), .THR(THR))
    u_n1 (
      .clk (clk),
      .rst (rst),
      .exc (l1_spk),
      .inh ({z_q, t1_q}),
      .mem (t1_mem),
      .spk (t1_q)
    );

  spk_neuron #(.N_EXC(1), .N_INH(2), .MEM_W(MEM_W), .LIM(LIM), .STEP(STEP), .THR(THR))
    u_n2 (
      .clk (clk),
      .rst (rst),
      .exc (l2_spk),
      .inh ({z_q, t2_q}),
      .mem (t2_mem),
      .spk (t2_q)
    );

  spk_neuron #(.N_EXC(2), .N_INH(1), .MEM_W(MEM_W), .LIM(LIM), .STEP(STEP), .THR(THR))
    u_n3 (
      .clk (clk),
      .rst (rst),
      .exc ({t2_q, t1_q}),
      .inh (gam_spk),
      .mem (z_mem),
      .spk (z_q)
    );

  assign t1_spk = t1_q;
  assign t2_spk = t2_q;
  assign z_spk  = z_q;
endmodule

// File: rtl/spk_mp_checker.sv
module spk_mp_checker #(
  parameter int MEM_W = 8,
  parameter int LIM   = 100,
  parameter int STEP  = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    l1_spk,
  input logic                    l2_spk,
  input logic                    t1_spk,
  input logic                    t2_spk,
  input logic                    z_spk,
  input logic signed [MEM_W-1:0] t1_mem,
  input logic signed [MEM_W-1:0] t2_mem,
  input logic signed [MEM_W-1:0] z_mem
);
  logic signed [31:0] t1_w;
  logic signed [31:0] t2_w;
  logic signed [31:0] z_w;
  logic signed [31:0] lim_w;
  logic               z_on_floor;

  assign t1_w  = 32'(t1_mem);
  assign t2_w  = 32'(t2_mem);
  assign z_w   = 32'(z_mem);
  assign lim_w = LIM;
  assign z_on_floor = (z_w == -lim_w);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (t1_mem == '0 && t2_mem == '0 && z_mem == '0 &&
                    !t1_spk && !t2_spk && !z_spk));

  p_mem_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (t1_w <= lim_w && t1_w >= -lim_w && t2_w <= lim_w && t2_w >= -lim_w &&
     z_w <= lim_w && z_w >= -lim_w));

  p_floor_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (z_on_floor && !t1_spk && !t2_spk) |=> z_on_floor);

  p_z_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((z_w - 32'($past(z_mem))) <= 2 * STEP &&
                     (z_w - 32'($past(z_mem))) >= -STEP));

  p_t1_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(t1_spk)) |-> $past(l1_spk));

  p_t2_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(t2_spk)) |-> $past(l2_spk));

  p_z_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(z_spk)) |-> $past(t1_spk || t2_spk));

  p_fire_sign_r3: assert property (@(posedge clk) disable iff (rst)
    (z_spk == (z_w > 0)) && (t1_spk == (t1_w > 0)) && (t2_spk == (t2_w > 0)));
endmodule

bind spk_mp_unit spk_mp_checker #(.MEM_W(MEM_W), .LIM(LIM), .STEP(STEP)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .l1_spk (l1_spk),
  .l2_spk (l2_spk),
  .t1_spk (t1_spk),
  .t2_spk (t2_spk),
  .z_spk  (z_spk),
  .t1_mem (t1_mem),
  .t2_mem (t2_mem),
  .z_mem  (z_mem)
);

// File: tb/test_spk_mp_unit.sv
`timescale 1ns/1ps
module test_spk_mp_unit;
  localparam int MEM_W  = 8;
  localparam int LIM    = 100;
  localparam int WARM   = 3000;
  localparam int WIN    = 20000;
  localparam real TOL   = 0.03;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l1_spk = 1'b0;
  logic l2_spk = 1'b0;
  logic gam_spk = 1'b0;
  logic t1_spk, t2_spk, z_spk;
  logic signed [MEM_W-1:0] t1_mem, t2_mem, z_mem;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] s1 = 32'h1234_5678;
  logic [31:0] s2 = 32'h9abc_def1;
  logic [31:0] s3 = 32'h0f1e_2d3c;

  always #10 clk = ~clk;

  spk_mp_unit #(.MEM_W(MEM_W), .LIM(LIM), .STEP(1), .THR(0)) i_spk_mp_unit (
    .clk(clk), .rst(rst), .l1_spk(l1_spk), .l2_spk(l2_spk), .gam_spk(gam_spk),
    .t1_spk(t1_spk), .t2_spk(t2_spk), .z_spk(z_spk),
    .t1_mem(t1_mem), .t2_mem(t2_mem), .z_mem(z_mem)
  );

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_real(input string req, input real act, input real exp);
    real d;
    checks++;
    d = act - exp;
    if (d < 0.0) d = -d;
    if (d > TOL) begin
      failures++;
      $display("FAIL %s actual=%0.4f expected=%0.4f", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; l1_spk = 1'b0; l2_spk = 1'b0; gam_spk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // R1: state while in reset
  task automatic t_reset();
    do_reset();
    chk_int("R1 t1_mem", int'(t1_mem), 0);
    chk_int("R1 z_mem", int'(z_mem), 0);
    chk_int("R1 spikes", int'({t1_spk, t2_spk, z_spk}), 0);
  endtask

  // R2/R3: exact trace of single spike through the loop
  task automatic t_trace();
    do_reset();
    rst = 1'b0; l1_spk = 1'b1;
    @(negedge clk);
    chk_int("R2 m1 after L1", int'(t1_mem), 1);
    chk_int("R3 t1 fires", int'(t1_spk), 1);
    chk_int("R2 m3 waits for registered t1", int'(z_mem), 0);
    l1_spk = 1'b0;
    @(negedge clk);
    chk_int("R2 m1 self-inhibited", int'(t1_mem), 0);
    chk_int("R3 t1 silent at zero", int'(t1_spk), 0);
    chk_int("R2 m3 excited by t1", int'(z_mem), 1);
    chk_int("R3 z fires", int'(z_spk), 1);
    @(negedge clk);
    chk_int("R2 m1 inhibited by z", int'(t1_mem), -1);
    chk_int("R2 m2 inhibited by z", int'(t2_mem), -1);
    chk_int("R2 m3 holds", int'(z_mem), 1);
  endtask

  // R4: floor saturation and linear recovery
  task automatic t_floor();
    do_reset();
    rst = 1'b0; gam_spk = 1'b1;
    repeat (150) @(negedge clk);
    chk_int("R4 z_mem at floor", int'(z_mem), -LIM);
    chk_int("R4 z silent", int'(z_spk), 0);
    chk_int("R2 gamma does not touch m1", int'(t1_mem), 0);
    gam_spk = 1'b0; l1_spk = 1'b1;
    repeat (10) @(negedge clk);
    chk_int("R4 z_mem climbs from floor", int'(z_mem), -LIM + 9);
    chk_int("R2 m1 steady with self-inhibition", int'(t1_mem), 1);
  endtask

  task automatic run_rates(input int p1, input int p2, input int pg,
                           output real r_t1, output real r_t2, output real r_z);
    int c1, c2, cz;
    c1 = 0; c2 = 0; cz = 0;
    do_reset();
    rst = 1'b0;
    for (int n = 0; n < WARM + WIN; n++) begin
      s1 = xs(s1); s2 = xs(s2); s3 = xs(s3);
      l1_spk  = (int'(s1[7:0]) < p1);
      l2_spk  = (int'(s2[7:0]) < p2);
      gam_spk = (int'(s3[7:0]) < pg);
      @(negedge clk);
      if (n >= WARM) begin
        c1 += int'(t1_spk); c2 += int'(t2_spk); cz += int'(z_spk);
      end
    end
    r_t1 = real'(c1) / WIN;
    r_t2 = real'(c2) / WIN;
    r_z  = real'(cz) / WIN;
  endtask

  function automatic real relu(input real v);
    return (v > 0.0) ? v : 0.0;
  endfunction

  task automatic t_mp(input string tag, input int p1, input int p2, input int pg);
    real a, b, g, zb, ze, r1, r2, rz;
    a = p1 / 256.0; b = p2 / 256.0; g = pg / 256.0;
    zb = (a + b - g) / 2.0;
    if (zb < a && zb < b) ze = zb;
    else ze = relu(((a > b) ? a : b) - g);
    run_rates(p1, p2, pg, r1, r2, rz);
    chk_real({"R6 sum equals gamma ", tag}, r1 + r2, g);
    chk_real({"R7 t1 margin ", tag}, r1, relu(a - rz));
    chk_real({"R7 t2 margin ", tag}, r2, relu(b - rz));
    chk_real({"R8 z solution ", tag}, rz, ze);
  endtask

  task automatic t_copy();
    real r1, r2, rz;
    run_rates(102, 51, 256, r1, r2, rz);
    chk_real("R5 t1 copies L1", r1, 102 / 256.0);
    chk_real("R5 t2 copies L2", r2, 51 / 256.0);
    chk_real("R5 z silent", rz, 0.0);
  endtask

  initial begin
    t_reset();
    t_trace();
    t_floor();
    t_mp("low L1", 26, 128, 77);
    t_mp("mid L1", 77, 128, 77);
    t_mp("high L1", 154, 128, 77);
    t_copy();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule